// File: doc/BRIEF.md
# Shift-Add Sine Reference with Split-Leg PWM

This block synthesises a low-frequency sine reference (60 Hz by default from a 48 MHz clock) without any lookup table and without a hardware multiplier. A 32-bit phase accumulator advances by a fixed step every clock. A sequencer repeatedly snapshots the top phase bits and folds the angle into the first quadrant. A rotation-mode CORDIC then runs one micro-rotation per clock to find the sine magnitude. A shift-add stage scales that magnitude by an 8-bit amplitude trim, and the sign is put back according to the quadrant.

Each finished sample is published together with its magnitude and the phase it was computed from. A first-order accumulator modulator turns the magnitude into a pulse stream. The pulses are steered to a positive-leg output while the sample is positive and to a negative-leg output while it is negative, so the two legs can drive the halves of an H-bridge. The magnitude output is also meant for a downstream power-dumping controller that needs |sin|.

Top module: `sine_bridge_ref`

## Requirements
- R1: While reset is asserted, and after it is released until the first sample is published, `sineOut`, `magOut`, `samplePhase`, `sampleStb`, `pwmPos` and `pwmNeg` are all zero.
- R2: The phase accumulator advances by round(2^32·TONE_HZ/CLK_HZ) each clock (5369 for the defaults, about 60.003 Hz). The top 16 bits of consecutive published phases therefore differ, modulo 2^16, by floor(18·step/2^16) or one more.
- R3: After reset is released, the first `sampleStb` pulse comes on the 18th rising edge. After that it pulses for exactly one cycle every 18 cycles (one load, 16 rotations, one publish).
- R4: `sineOut` is within 4 LSB of 32000·(trim/256)·sin(2π·samplePhase/65536), and the largest |sineOut| seen over a period is within 6 LSB of floor(32000·trim/256).
- R5: Phases with the top bit 0 (first half turn) give `sineOut` ≥ 0, and phases with the top bit 1 give `sineOut` ≤ 0.
- R6: `magOut` equals |sineOut| for every published sample.
- R7: With a trim of 0, every published sample is 0 and neither leg pulses.
- R8: `pwmPos` and `pwmNeg` are never high in the same cycle.
- R9: The 18 modulator outputs that follow a publish carry floor(18·magOut/32768) or one more pulses in total. With a magnitude of 0 they carry none.
- R10: Pulses appear only on `pwmPos` while the current sample is positive, and only on `pwmNeg` while it is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ampTrim | input | 8 | Amplitude trim, gain = ampTrim/256, sampled at each publish |
| sineOut | output | 16 | Signed trimmed sine sample |
| magOut | output | 15 | Magnitude of `sineOut` |
| samplePhase | output | 16 | Top phase bits used for the published sample |
| sampleStb | output | 1 | One-cycle pulse when a new sample is published |
| pwmPos | output | 1 | Positive-leg pulse stream |
| pwmNeg | output | 1 | Negative-leg pulse stream |

## Verification
The bench runs the phase much faster than 60 Hz so that many full turns fit in the run. This lets it reach every quadrant boundary, where a wrong fold mirrors the wave or drops its sign. A wrong micro-rotation angle or shift shows up as a sample error well above a few LSB near the peaks. The trim is swept from 0 through 1 up to 255: a broken shift-add product gives a wrong peak, and a trim of 0 that leaks gives stray leg pulses. Pulses are counted in each 18-cycle window. Counting catches a modulator that loses its carry, steers a pulse to the wrong leg, or fires at zero magnitude. A sequencer with a wrong cycle count shows up in the spacing of the publish strobes and in the phase step.

// File: rtl/sine_ref_pkg.sv
package sine_ref_pkg;

  // angle units: a quarter turn equals 2**QTR_BITS
  localparam int QTR_BITS = 18;
  localparam int ZW       = QTR_BITS + 2;
  localparam int IDX_W    = 5;

  typedef struct packed {
    logic             load;    // snapshot phase, seed x/y/z
    logic             rotate;  // one micro-rotation
    logic [IDX_W-1:0] idx;     // rotation index
    logic             finish;  // publish sample
  } cordic_ctrl_t;

  // arctan(2^-i) in units of a quarter turn / 2**QTR_BITS
  function automatic logic signed [ZW-1:0] atan_step(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:    atan_step = ZW'(131072);
      5'd1:    atan_step = ZW'(77376);
      5'd2:    atan_step = ZW'(40884);
      5'd3:    atan_step = ZW'(20753);
      5'd4:    atan_step = ZW'(10417);
      5'd5:    atan_step = ZW'(5213);
      5'd6:    atan_step = ZW'(2607);
      5'd7:    atan_step = ZW'(1304);
      5'd8:    atan_step = ZW'(652);
      5'd9:    atan_step = ZW'(326);
      5'd10:   atan_step = ZW'(163);
      5'd11:   atan_step = ZW'(81);
      5'd12:   atan_step = ZW'(41);
      5'd13:   atan_step = ZW'(20);
      5'd14:   atan_step = ZW'(10);
      5'd15:   atan_step = ZW'(5);
      default: atan_step = '0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_seq.sv
module cordic_seq
  import sine_ref_pkg::*;
#(
  parameter int ITER = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output cordic_ctrl_t ctl
);

  localparam int LAST  = ITER + 1;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     stepCnt <= '0;
    else if (stepCnt == CNT_W'(LAST)) stepCnt <= '0;
    else                            stepCnt <= stepCnt + 1'b1;
  end

  always_comb begin
    ctl.load   = (stepCnt == '0);
    ctl.finish = (stepCnt == CNT_W'(LAST));
    ctl.rotate = !ctl.load && !ctl.finish;
    ctl.idx    = IDX_W'(stepCnt - 1'b1);
  end

  // R3: publish lasts a single cycle and is followed by a fresh load
  p_finish_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |=> !ctl.finish);
  p_load_after_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |=> ctl.load);

endmodule

// File: rtl/cordic_path.sv
module cordic_path
  import sine_ref_pkg::*;
#(
  parameter int CLK_HZ  = 48_000_000,
  parameter int TONE_HZ = 60,
  parameter int DATA_W  = 16,
  parameter int TRIM_W  = 8,
  parameter int AMP     = 32000,
  parameter int PHASE_W = 32,
  parameter int ANG_W   = 16,
  parameter int GUARD   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cordic_ctrl_t             ctl,
  input  logic [TRIM_W-1:0]        ampTrim,
  output logic signed [DATA_W-1:0] sineOut,
  output logic [DATA_W-2:0]        magOut,
  output logic [ANG_W-1:0]         samplePhase,
  output logic                     sampleStb
);

  localparam int MAG_W  = DATA_W - 1;
  localparam int IW     = DATA_W + GUARD + 2;
  localparam int PROD_W = MAG_W + TRIM_W;
  localparam int ZSH    = QTR_BITS - (ANG_W - 2);
  localparam logic [PHASE_W-1:0] PHASE_INC =
    PHASE_W'(((longint'(TONE_HZ) << PHASE_W) + longint'(CLK_HZ / 2)) / longint'(CLK_HZ));
  // K = 0.6072529 ~ 39797/65536, pre-applied so the vector ends at AMP
  localparam longint X_INIT = (longint'(AMP) * 39797 * (longint'(1) << GUARD) + 32768) >>> 16;
  localparam logic signed [IW-1:0] HALF    = IW'(1 << (GUARD - 1));
  localparam logic signed [IW-1:0] MAG_MAX = IW'((1 << MAG_W) - 1);
  localparam logic [ANG_W-2:0]     QTR     = (ANG_W-1)'(1 << (ANG_W - 2));

  logic [PHASE_W-1:0]    phaseAcc;
  logic [ANG_W-1:0]      phHold;
  logic [1:0]            quad;
  logic signed [IW-1:0]  xr, yr;
  logic signed [ZW-1:0]  zr;

  // free-running angle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phaseAcc <= '0;
    else        phaseAcc <= phaseAcc + PHASE_INC;
  end

  // first-quadrant fold
  logic [ANG_W-3:0] lowAng;
  logic [ANG_W-2:0] foldAng;
  assign lowAng  = phaseAcc[PHASE_W-3 -: (ANG_W-2)];
  assign foldAng = phaseAcc[PHASE_W-2] ? (QTR - {1'b0, lowAng}) : {1'b0, lowAng};

  // micro-rotation
  logic signed [IW-1:0] xSh, ySh;
  logic signed [ZW-1:0] zStep;
  assign xSh   = xr >>> ctl.idx;
  assign ySh   = yr >>> ctl.idx;
  assign zStep = atan_step(ctl.idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr <= '0; yr <= '0; zr <= '0; quad <= '0; phHold <= '0;
    end else if (ctl.load) begin
      xr     <= IW'(X_INIT);
      yr     <= '0;
      zr     <= $signed({{(ZW-ANG_W+1){1'b0}}, foldAng} << ZSH);
      quad   <= phaseAcc[PHASE_W-1 -: 2];
      phHold <= phaseAcc[PHASE_W-1 -: ANG_W];
    end else if (ctl.rotate) begin
      if (!zr[ZW-1]) begin
        xr <= xr - ySh; yr <= yr + xSh; zr <= zr - zStep;
      end else begin
        xr <= xr + ySh; yr <= yr - xSh; zr <= zr + zStep;
      end
    end
  end

  // round off guard bits, clamp to the magnitude range
  logic signed [IW-1:0] yRnd;
  logic [MAG_W-1:0]     magRaw;
  assign yRnd = (yr + HALF) >>> GUARD;
  always_comb begin
    if (yRnd[IW-1])           magRaw = '0;
    else if (yRnd > MAG_MAX)  magRaw = MAG_W'(MAG_MAX);
    else                      magRaw = yRnd[MAG_W-1:0];
  end

  // shift-add amplitude trim
  logic [PROD_W-1:0] partial [TRIM_W];
  logic [PROD_W-1:0] prodSum;
  logic [MAG_W-1:0]  magTrim;
  for (genvar k = 0; k < TRIM_W; k++) begin : g_trim
    assign partial[k] = ampTrim[k] ? ({{TRIM_W{1'b0}}, magRaw} << k) : '0;
  end
  always_comb begin
    prodSum = '0;
    for (int k = 0; k < TRIM_W; k++) prodSum = prodSum + partial[k];
  end
  assign magTrim = prodSum[PROD_W-1 -: MAG_W];

  // publish with sign restored from the half-turn bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sineOut <= '0; magOut <= '0; samplePhase <= '0; sampleStb <= 1'b0;
    end else begin
      sampleStb <= ctl.finish;
      if (ctl.finish) begin
        sineOut     <= quad[1] ? -$signed({1'b0, magTrim}) : $signed({1'b0, magTrim});
        magOut      <= magTrim;
        samplePhase <= phHold;
      end
    end
  end

  // R5: sign follows the half-turn bit of the published phase
  p_quadrant_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> (samplePhase[ANG_W-1] ? (sineOut <= 0) : (sineOut >= 0)));
  // R6: magnitude matches the signed sample
  p_mag_abs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> (DATA_W'(magOut) == (sineOut[DATA_W-1] ? -sineOut : sineOut)));

endmodule

// File: rtl/leg_modulator.sv
module leg_modulator #(
  parameter int MAG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] mag,
  input  logic             negSide,
  output logic             pwmPos,
  output logic             pwmNeg
);

  logic [MAG_W-1:0] acc;
  logic [MAG_W:0]   accNext;
  assign accNext = {1'b0, acc} + {1'b0, mag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; pwmPos <= 1'b0; pwmNeg <= 1'b0;
    end else begin
      acc    <= accNext[MAG_W-1:0];
      pwmPos <= accNext[MAG_W] && !negSide;
      pwmNeg <= accNext[MAG_W] &&  negSide;
    end
  end

  // R8: legs are mutually exclusive
  p_legs_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwmPos && pwmNeg));

endmodule

// File: rtl/sine_bridge_ref.sv
module sine_bridge_ref
  import sine_ref_pkg::*;
#(
  parameter int CLK_HZ  = 48_000_000,
  parameter int TONE_HZ = 60,
  parameter int DATA_W  = 16,
  parameter int TRIM_W  = 8,
  parameter int AMP     = 32000,
  parameter int ITER    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TRIM_W-1:0]        ampTrim,
  output logic signed [DATA_W-1:0] sineOut,
  output logic [DATA_W-2:0]        magOut,
  output logic [15:0]              samplePhase,
  output logic                     sampleStb,
  output logic                     pwmPos,
  output logic                     pwmNeg
);

  cordic_ctrl_t ctl;

  cordic_seq #(.ITER(ITER)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl(ctl)
  );

  cordic_path #(
    .CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .DATA_W(DATA_W),
    .TRIM_W(TRIM_W), .AMP(AMP), .PHASE_W(32), .ANG_W(16), .GUARD(2)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .ampTrim(ampTrim),
    .sineOut(sineOut), .magOut(magOut),
    .samplePhase(samplePhase), .sampleStb(sampleStb)
  );

  leg_modulator #(.MAG_W(DATA_W-1)) u_mod (
    .clk(clk), .rst_n(rst_n), .mag(magOut), .negSide(sineOut[DATA_W-1]),
    .pwmPos(pwmPos), .pwmNeg(pwmNeg)
  );

  // R10: each leg pulses only for a sample of its own sign
  p_pos_leg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwmPos |-> ($past(sineOut) > 0));
  p_neg_leg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwmNeg |-> ($past(sineOut) < 0));

endmodule

// File: tb/tb_sine_bridge_ref.sv
module tb_sine_bridge_ref;

  localparam int TONE    = 6000;
  localparam int CLKHZ   = 48_000_000;
  localparam int AMPL    = 32000;
  localparam int PERIOD  = 18;
  localparam int SAMPLES = 500;
  localparam longint INC = ((longint'(TONE) << 32) + longint'(CLKHZ / 2)) / longint'(CLKHZ);
  localparam int STEP_LO = int'((longint'(PERIOD) * INC) >> 16);

  typedef struct packed { logic [7:0] trim; logic [15:0] peak; } vec_t;
  localparam vec_t VECS [0:5] = '{
    '{8'd255, 16'd31875}, '{8'd128, 16'd16000}, '{8'd37, 16'd4625},
    '{8'd1,   16'd125},   '{8'd0,   16'd0},     '{8'd200, 16'd25000}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ampTrim = 8'd255;
  logic signed [15:0] sineOut;
  logic [14:0] magOut;
  logic [15:0] samplePhase;
  logic sampleStb, pwmPos, pwmNeg;

  always #4 clk = ~clk;

  sine_bridge_ref #(.TONE_HZ(TONE)) dut (
    .clk(clk), .rst_n(rst_n), .ampTrim(ampTrim), .sineOut(sineOut),
    .magOut(magOut), .samplePhase(samplePhase), .sampleStb(sampleStb),
    .pwmPos(pwmPos), .pwmNeg(pwmNeg));

  int checks = 0, fails = 0, cyc = 0, lastStb = -1, maxMag = 0;
  bit checking = 0, winOn = 0, prevOk = 0, done = 0;
  int winLen, winP, winN, winBoth, winMag, winSign;
  logic [15:0] prevPh;

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0f expected=%0f", req, act, exp);
    end
  endtask

  task automatic closeWin();
    int lo = (PERIOD * winMag) >> 15;
    int tot = winP + winN;
    chk(winBoth == 0, "R8 both legs high", real'(winBoth), 0.0);
    if (winMag == 0) chk(tot == 0, "R9 pulses at zero magnitude", real'(tot), 0.0);
    else chk(tot == lo || tot == lo + 1, "R9 pulse count", real'(tot), real'(lo));
    if (winSign > 0)      chk(winN == 0, "R10 neg leg on positive sample", real'(winN), 0.0);
    else if (winSign < 0) chk(winP == 0, "R10 pos leg on negative sample", real'(winP), 0.0);
    else                  chk(tot == 0, "R10 pulse on zero sample", real'(tot), 0.0);
  endtask

  task automatic checkSample();
    real ang = 2.0 * 3.14159265358979 * real'(samplePhase) / 65536.0;
    real expv = real'(AMPL) * $sin(ang) * real'(ampTrim) / 256.0;
    real diff = real'(sineOut) - expv;
    int absS = (sineOut < 0) ? -int'(sineOut) : int'(sineOut);
    chk(diff <= 4.0 && diff >= -4.0, "R4 sample accuracy", real'(sineOut), expv);
    chk(samplePhase[15] ? (sineOut <= 0) : (sineOut >= 0), "R5 quadrant sign",
        real'(sineOut), real'(samplePhase));
    chk(int'(magOut) == absS, "R6 magnitude", real'(magOut), real'(absS));
    if (ampTrim == 0) chk(sineOut == 0, "R7 zero trim sample", real'(sineOut), 0.0);
    if (prevOk) begin
      int d = int'(16'(samplePhase - prevPh));
      chk(d == STEP_LO || d == STEP_LO + 1, "R2 phase step", real'(d), real'(STEP_LO));
    end
    if (lastStb >= 0) chk(cyc - lastStb == PERIOD, "R3 strobe spacing",
                          real'(cyc - lastStb), real'(PERIOD));
    if (absS > maxMag) maxMag = absS;
    prevPh = samplePhase; prevOk = 1;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (winOn) begin
      if (pwmPos && pwmNeg) winBoth++;
      winP += int'(pwmPos); winN += int'(pwmNeg); winLen++;
    end
    if (sampleStb) begin
      if (winOn && winLen == PERIOD) closeWin();
      if (checking) checkSample();
      lastStb = checking ? cyc : -1;
      winOn = checking; winLen = 0; winP = 0; winN = 0; winBoth = 0;
      winMag = int'(magOut); winSign = int'(sineOut);
    end
  endtask

  task automatic waitStb(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      while (!sampleStb) step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sineOut == 0 && magOut == 0 && samplePhase == 0 && !sampleStb && !pwmPos && !pwmNeg,
        "R1 outputs in reset", real'(sineOut), 0.0);
    rst_n = 1'b1;
    begin
      int n = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); n++;
        if (n == 5) chk(sineOut == 0 && magOut == 0 && !sampleStb && !pwmPos && !pwmNeg,
                        "R1 outputs before first sample", real'(magOut), 0.0);
        if (sampleStb) break;
      end
      chk(n == PERIOD, "R3 first strobe cycle", real'(n), real'(PERIOD));
    end
    // vector table walk
    for (int v = 0; v < 6; v++) begin
      ampTrim = VECS[v].trim;
      checking = 0; winOn = 0; prevOk = 0; lastStb = -1;
      waitStb(2);
      checking = 1; maxMag = 0;
      lastStb = cyc;
      prevPh = samplePhase; prevOk = 1;
      winOn = 1; winLen = 0; winP = 0; winN = 0; winBoth = 0;
      winMag = int'(magOut); winSign = int'(sineOut);
      waitStb(SAMPLES);
      chk(maxMag >= int'(VECS[v].peak) - 6 && maxMag <= int'(VECS[v].peak) + 6,
          "R4 peak amplitude", real'(maxMag), real'(VECS[v].peak));
    end
    // R7: zero trim, legs silent over a long stretch
    ampTrim = 8'd0; checking = 0; winOn = 0;
    waitStb(2);
    begin
      int pulses = 0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        pulses += int'(pwmPos) + int'(pwmNeg);
      end
      chk(pulses == 0, "R7 legs idle at zero trim", real'(pulses), 0.0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule